// File: doc/BRIEF.md
# Self-Repairing Minutes-and-Seconds Cell Array

A one-dimensional row of identical counter cells that together keep time in minutes and seconds (00:00 to 59:59). Every cell carries the complete genome: a decimal (wrap after 9) gene and a senary (wrap after 5) gene. A cell does not own a fixed job. It works out its coordinate as the number of healthy cells to its left, and the coordinate picks which gene it runs. Even coordinates run the decimal gene and odd coordinates run the senary gene. So coordinate 0 is seconds units, 1 is seconds tens, 2 is minutes units and 3 is minutes tens. Cells whose coordinate is at or beyond the number of roles are idle spares.

An external detector supplies one fault flag per cell. A flagged cell is skipped when coordinates are counted. Every cell to its right therefore moves down one coordinate, and the first spare is pulled into service. Digit values are held per coordinate and not per cell, so on the edge where the mapping changes, each newly assigned cell loads the digit its coordinate held. The displayed time survives the repair, and a tick on that same edge is still counted. Two flags report the repair state. One says that faults are present and fully covered by spares. The other says that more cells have failed than there are spares.

Top module: `sr_clock_array`

## Requirements
- R1: While `rst_n` is low at a clock edge, all digits become 0 and both `repaired_o` and `error_o` become 0.
- R2: The digit at coordinate 0 (bits [3:0] of `digits_o`) advances by one on every clock edge where `tick_i` is 1, and goes from 9 to 0.
- R3: The digit at coordinate 1 (bits [7:4]) advances only on an edge where coordinate 0 goes from 9 to 0, and goes from 5 to 0.
- R4: The digit at coordinate 2 (bits [11:8]) advances only when the seconds go from 59 to 00, and goes from 9 to 0.
- R5: The digit at coordinate 3 (bits [15:12]) advances only when coordinate 2 wraps while carrying in, and goes from 5 to 0. 59:59 is followed by 00:00.
- R6: An edge with `tick_i` low and an unchanged fault vector leaves every digit unchanged.
- R7: While at most N_SPARE cells are flagged, flagging any active cell leaves the displayed time unchanged, and counting continues from that value.
- R8: A cell's coordinate equals the number of unflagged cells below it. Flags on cells above the last active one therefore have no effect on the display.
- R9: One edge after the fault vector holds between 1 and N_SPARE set bits, `repaired_o` is 1 and `error_o` is 0. With no bits set, both are 0.
- R10: One edge after more than N_SPARE bits are set, `error_o` is 1 and `repaired_o` is 0. Coordinates below the healthy-cell count keep their digits, and coordinates without a cell read 0.
- R11: When the fault vector changes on the same edge as a tick, the digits both migrate and advance by that tick.
- R12: Clearing all fault flags moves every role back to its original cell with the displayed time unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_i | input | 1 | One-second enable pulse |
| fault_i | input | N_ROLES+N_SPARE | Per-cell fault flag, bit i for cell i |
| digits_o | output | 4*N_ROLES | Digit of coordinate c at bits [4c+3:4c] |
| repaired_o | output | 1 | Faults present and all covered by spares |
| error_o | output | 1 | More faulty cells than spares |

## Verification
The hardest situation to reach is a change in the coordinate mapping that lands on the same edge as a tick while the digits are non-zero. In that case a digit has to migrate and advance at once. It must also migrate whether the newly mapped cell is a spare or a cell that shifted down. The stimulus first advances the time to a value where every digit is non-zero. It then walks through every one of the 64 fault vectors of a six-cell array, changing each vector on an edge that carries a tick for about half of the vectors. After each change it checks the time against an arithmetic seconds model. Vectors that exceed the spare count are checked for which coordinates survive, and a reset then re-seeds the model.

// File: rtl/sr_clock_pkg.sv
// Shared definitions for the self-repairing clock array.
// Assumes roles alternate decimal/senary starting with decimal at coordinate 0.
package sr_clock_pkg;

    localparam int DIGIT_W = 4;

    typedef logic [DIGIT_W-1:0] digit_t;

    typedef enum logic {
        GENE_DEC = 1'b0,   // wraps after 9
        GENE_SEN = 1'b1    // wraps after 5
    } gene_e;

    // Selects the gene a cell runs from its coordinate.
    function automatic gene_e gene_of(input int unsigned coord);
        return (coord % 2 == 0) ? GENE_DEC : GENE_SEN;
    endfunction

    // Returns the last value a gene reaches before wrapping to zero.
    function automatic digit_t gene_top(input gene_e g);
        return (g == GENE_DEC) ? digit_t'(9) : digit_t'(5);
    endfunction

endpackage

// File: rtl/sr_coord_map.sv
// Coordinate assignment: each cell's coordinate is the count of unflagged
// cells below it. Also reports whether any flag is set and whether the
// healthy cells are too few to cover every role.
// Assumes fault flags are synchronous to clk.
module sr_coord_map #(
    parameter int N_CELLS = 6,
    parameter int N_ROLES = 4,
    localparam int CW     = $clog2(N_CELLS + 1)
) (
    input  logic [N_CELLS-1:0] fault_i,
    output logic [CW-1:0]      coord_o [N_CELLS],
    output logic               any_fault_o,
    output logic               short_o
);

    logic [CW-1:0] healthy;

    // Prefix count of healthy cells gives each cell's coordinate.
    always_comb begin
        healthy = '0;
        for (int i = 0; i < N_CELLS; i++) begin
            coord_o[i] = healthy;
            if (!fault_i[i]) begin
                healthy = healthy + CW'(1);
            end
        end
    end

    // Summary flags derived from the healthy count.
    always_comb begin
        any_fault_o = |fault_i;
        short_o     = (healthy < CW'(N_ROLES));
    end

endmodule

// File: rtl/sr_digit_view.sv
// Coordinate-space view of the registered cell state: gathers the digit
// held for each coordinate and ripples the count enable from coordinate 0
// upward. Only registered state and the tick feed this logic.
// Assumes at most one live cell claims any coordinate.
module sr_digit_view
    import sr_clock_pkg::*;
#(
    parameter int N_CELLS = 6,
    parameter int N_ROLES = 4,
    localparam int CW     = $clog2(N_CELLS + 1)
) (
    input  logic          tick_i,
    input  logic          live_q_i  [N_CELLS],
    input  logic [CW-1:0] coord_q_i [N_CELLS],
    input  digit_t        digit_q_i [N_CELLS],
    output digit_t        view_o    [N_ROLES],
    output logic          en_o      [N_ROLES]
);

    // Collects, per coordinate, the digit of the live cell that holds it.
    always_comb begin
        for (int c = 0; c < N_ROLES; c++) begin
            view_o[c] = '0;
            for (int i = 0; i < N_CELLS; i++) begin
                if (live_q_i[i] && coord_q_i[i] == CW'(c)) begin
                    view_o[c] = view_o[c] | digit_q_i[i];
                end
            end
        end
    end

    // Carry ripple: a coordinate counts when the one below wraps while counting.
    always_comb begin
        en_o[0] = tick_i;
        for (int c = 1; c < N_ROLES; c++) begin
            en_o[c] = en_o[c-1] &&
                      (view_o[c-1] == gene_top(gene_of(unsigned'(c - 1))));
        end
    end

endmodule

// File: rtl/sr_counter_cell.sv
// One cell of the array. Holds the whole genome, picks a gene from its
// coordinate, and on each edge loads the digit its new coordinate held,
// advancing it when enabled. Spare and faulty cells hold zero.
// Assumes inherit_i/en_i belong to coord_i as seen before the edge.
module sr_counter_cell
    import sr_clock_pkg::*;
#(
    parameter int N_CELLS = 6,
    parameter int N_ROLES = 4,
    localparam int CW     = $clog2(N_CELLS + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          fault_i,
    input  logic [CW-1:0] coord_i,
    input  digit_t        inherit_i,
    input  logic          en_i,
    output digit_t        digit_o,
    output logic [CW-1:0] coord_o,
    output logic          live_o
);

    logic   live_n;
    gene_e  gene;
    digit_t next_digit;

    // Gene selection and next-digit computation for the coming edge.
    always_comb begin
        live_n = !fault_i && (coord_i < CW'(N_ROLES));
        gene   = gene_of(unsigned'(32'(coord_i)));
        if (!live_n) begin
            next_digit = '0;
        end else if (en_i) begin
            next_digit = (inherit_i == gene_top(gene)) ? '0 : inherit_i + digit_t'(1);
        end else begin
            next_digit = inherit_i;
        end
    end

    // Cell state register: digit, coordinate and live flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            digit_o <= '0;
            coord_o <= '0;
            live_o  <= 1'b0;
        end else begin
            digit_o <= next_digit;
            coord_o <= coord_i;
            live_o  <= live_n;
        end
    end

endmodule

// File: rtl/sr_clock_array.sv
// Top of the self-repairing minutes-and-seconds array. Maps coordinates
// from the fault flags, routes each coordinate's digit and enable to the
// cell that will hold it, and drives the packed digit output and flags.
// Assumes tick_i is a single-cycle pulse per second.
module sr_clock_array
    import sr_clock_pkg::*;
#(
    parameter int N_ROLES  = 4,
    parameter int N_SPARE  = 2,
    localparam int N_CELLS = N_ROLES + N_SPARE,
    localparam int CW      = $clog2(N_CELLS + 1)
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       tick_i,
    input  logic [N_CELLS-1:0]         fault_i,
    output logic [N_ROLES*DIGIT_W-1:0] digits_o,
    output logic                       repaired_o,
    output logic                       error_o
);

    logic [CW-1:0] coord_n   [N_CELLS];
    logic [CW-1:0] coord_q   [N_CELLS];
    logic          live_q    [N_CELLS];
    digit_t        digit_q   [N_CELLS];
    digit_t        inherit   [N_CELLS];
    logic          en_cell   [N_CELLS];
    digit_t        view      [N_ROLES];
    logic          en_coord  [N_ROLES];
    logic          any_fault;
    logic          short_cells;

    sr_coord_map #(
        .N_CELLS (N_CELLS),
        .N_ROLES (N_ROLES)
    ) u_map (
        .fault_i     (fault_i),
        .coord_o     (coord_n),
        .any_fault_o (any_fault),
        .short_o     (short_cells)
    );

    sr_digit_view #(
        .N_CELLS (N_CELLS),
        .N_ROLES (N_ROLES)
    ) u_view (
        .tick_i    (tick_i),
        .live_q_i  (live_q),
        .coord_q_i (coord_q),
        .digit_q_i (digit_q),
        .view_o    (view),
        .en_o      (en_coord)
    );

    // Routes each coordinate's held digit and enable to its new cell.
    always_comb begin
        for (int i = 0; i < N_CELLS; i++) begin
            inherit[i] = '0;
            en_cell[i] = 1'b0;
            for (int c = 0; c < N_ROLES; c++) begin
                if (coord_n[i] == CW'(c)) begin
                    inherit[i] = view[c];
                    en_cell[i] = en_coord[c];
                end
            end
        end
    end

    for (genvar g = 0; g < N_CELLS; g++) begin : g_cell
        sr_counter_cell #(
            .N_CELLS (N_CELLS),
            .N_ROLES (N_ROLES)
        ) u_cell (
            .clk       (clk),
            .rst_n     (rst_n),
            .fault_i   (fault_i[g]),
            .coord_i   (coord_n[g]),
            .inherit_i (inherit[g]),
            .en_i      (en_cell[g]),
            .digit_o   (digit_q[g]),
            .coord_o   (coord_q[g]),
            .live_o    (live_q[g])
        );
    end

    for (genvar r = 0; r < N_ROLES; r++) begin : g_out
        assign digits_o[r*DIGIT_W +: DIGIT_W] = view[r];
    end

    // Repair status flags registered alongside the cell state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            repaired_o <= 1'b0;
            error_o    <= 1'b0;
        end else begin
            repaired_o <= any_fault && !short_cells;
            error_o    <= short_cells;
        end
    end

endmodule

// File: rtl/sr_clock_checker.sv
// Property checker for sr_clock_array, attached with bind below.
module sr_clock_checker
    import sr_clock_pkg::*;
#(
    parameter int N_ROLES  = 4,
    parameter int N_SPARE  = 2,
    localparam int N_CELLS = N_ROLES + N_SPARE
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       tick_i,
    input logic [N_CELLS-1:0]         fault_i,
    input logic [N_ROLES*DIGIT_W-1:0] digits_o,
    input logic                       repaired_o,
    input logic                       error_o
);

    // R9 / R10: the two status flags are never high together.
    p_flags_exclusive_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !(error_o && repaired_o));

    // R10: too many faults raise the error flag on the next edge.
    p_error_raise_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ($countones(fault_i) > N_SPARE) |=> error_o);

    // R9: a covered fault set raises the repaired flag on the next edge.
    p_repaired_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (fault_i != '0 && $countones(fault_i) <= N_SPARE) |=> (repaired_o && !error_o));

    // R6: no tick and no mapping change keeps every digit.
    p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick_i && $stable(fault_i)) |=> $stable(digits_o));

    // R2: seconds units step by one per tick when the array is covered.
    p_units_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_i && $stable(fault_i) && $countones(fault_i) <= N_SPARE) |=>
        (digits_o[3:0] == (($past(digits_o[3:0]) == 4'd9) ? 4'd0 : $past(digits_o[3:0]) + 4'd1)));

    // R3 / R5: no digit ever exceeds the top value of its gene.
    for (genvar c = 0; c < N_ROLES; c++) begin : g_range
        p_digit_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
            digits_o[c*DIGIT_W +: DIGIT_W] <= gene_top(gene_of(unsigned'(c))));
    end

endmodule

bind sr_clock_array sr_clock_checker #(
    .N_ROLES (N_ROLES),
    .N_SPARE (N_SPARE)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick_i     (tick_i),
    .fault_i    (fault_i),
    .digits_o   (digits_o),
    .repaired_o (repaired_o),
    .error_o    (error_o)
);

// File: tb/sim_sr_clock_array.sv
`timescale 1ns/100ps
module sim_sr_clock_array;

    localparam int NR = 4;
    localparam int NS = 2;
    localparam int NC = NR + NS;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          tick = 1'b0;
    logic [NC-1:0] fault = '0;
    logic [NR*4-1:0] digits;
    logic          repaired;
    logic          err;

    int total = 0;
    int bad = 0;
    int ref_s = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    sr_clock_array #(.N_ROLES(NR), .N_SPARE(NS)) u0 (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick_i     (tick),
        .fault_i    (fault),
        .digits_o   (digits),
        .repaired_o (repaired),
        .error_o    (err)
    );

    function automatic int exp_digit(input int s, input int c);
        case (c)
            0: return s % 10;
            1: return (s / 10) % 6;
            2: return (s / 60) % 10;
            default: return (s / 600) % 6;
        endcase
    endfunction

    task automatic check(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic check_time(input string tag);
        for (int c = 0; c < NR; c++)
            check(tag, int'(digits[c*4 +: 4]), exp_digit(ref_s, c));
    endtask

    // Drives one edge's inputs at the falling edge and samples after the rise.
    task automatic step(input logic t, input logic [NC-1:0] f);
        @(negedge clk);
        tick  = t;
        fault = f;
        @(posedge clk);
        #1;
        if (t) ref_s = (ref_s + 1) % 3600;
        tick = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        fault = '0;
        tick  = 1'b0;
        repeat (2) @(posedge clk);
        #1;
        rst_n = 1'b1;
        ref_s = 0;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        do_reset();
        // R1: reset state
        check("R1 digits", int'(digits), 0);
        check("R1 repaired", int'(repaired), 0);
        check("R1 error", int'(err), 0);

        // R6: idle edges hold
        for (int k = 0; k < 3; k++) begin
            step(1'b0, '0);
            check_time("R6");
        end

        // R2..R5: full hour plus wrap, each digit against the seconds model
        for (int k = 0; k < 3601; k++) begin
            step(1'b1, '0);
            check("R2", int'(digits[3:0]),   exp_digit(ref_s, 0));
            check("R3", int'(digits[7:4]),   exp_digit(ref_s, 1));
            check("R4", int'(digits[11:8]),  exp_digit(ref_s, 2));
            check("R5", int'(digits[15:12]), exp_digit(ref_s, 3));
        end

        // Advance to 11:11 so every digit is non-zero.
        for (int k = 0; k < 670; k++) step(1'b1, '0);

        // Sweep every fault vector.
        for (int m = 1; m < (1 << NC); m++) begin
            logic [NC-1:0] fv;
            int pop;
            fv  = NC'(m);
            pop = $countones(fv);
            if (pop <= NS) begin
                logic t;
                t = fv[0] ^ fv[3];
                step(t, fv);
                if (t) check_time("R11");
                else if (fv[NR-1:0] == '0) check_time("R8");
                else check_time("R7");
                check("R9 repaired", int'(repaired), 1);
                check("R9 error", int'(err), 0);
                for (int k = 0; k < 7; k++) begin
                    step(1'b1, fv);
                    check_time("R7");
                end
                step(1'b0, fv);
                check_time("R6");
                step(1'b0, '0);
                check_time("R12");
                check("R9 cleared", int'(repaired), 0);
            end else begin
                step(1'b0, fv);
                check("R10 error", int'(err), 1);
                check("R10 repaired", int'(repaired), 0);
                for (int c = 0; c < NR; c++) begin
                    if (c < NC - pop) check("R10 kept", int'(digits[c*4 +: 4]), exp_digit(ref_s, c));
                    else check("R10 lost", int'(digits[c*4 +: 4]), 0);
                end
                do_reset();
                check("R1 after reset", int'(digits), 0);
                for (int k = 0; k < 671; k++) step(1'b1, '0);
            end
        end

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule